// File: doc/BRIEF.md
# Dual-Destination Slave FIFO Write Sequencer

This block is the FPGA-side master of a synchronous slave-FIFO port on a USB bridge. It drives a 5-bit FIFO address, a write strobe, a packet-end strobe and an endpoint-switch strobe. It watches two flags that the bridge reports for the addressed FIFO: a ready flag and a watermark flag. Words come from two upstream streaming sources with valid/ready handshakes. The long source feeds multi-word packets to address 2. The short source feeds one-word packets to address 6.

Both destinations sit on one hardware thread of the bridge, so the block serves them in strict turns. At the start of each turn it drives the new address and pulses the endpoint-switch strobe low. It then waits a fixed settling time and samples the flags once. If the FIFO is not ready, or the selected source has nothing to send, the turn is dropped and the other address is served next. Otherwise the block writes. A long packet ends when it reaches a word cap, or at once when the watermark flag is seen high. Every short packet is a single word. The last write of each packet carries the packet-end strobe in the same cycle.

Top module: `slvfifo_wr_ctrl`

## Requirements
- R1: While reset is held, bus_wr_n, bus_pktend_n and bus_epsw_n are high, bus_addr is 2 and neither source ready is high.
- R2: bus_addr only ever shows 2 (long destination) or 6 (short destination). Each turn moves to the other value, and the first turn after reset is address 2.
- R3: bus_epsw_n is low for exactly one cycle: the first cycle in which a new address is shown. It is high in all other cycles.
- R4: No write occurs sooner than SETTLE+1 cycles after an address change, so flag values before then have no effect. With the flag ready and data present, the first write of the turn falls exactly SETTLE+1 cycles after the change (default SETTLE = 3, so 4 cycles).
- R5: bus_wr_n is low only in cycles where bus_ready is high. A long burst pauses while ready is low and resumes without losing its count.
- R6: If, in the check cycle, bus_ready is low or the selected source has no word, no write is made and the next address is shown in the following cycle. Turns that skip are therefore SETTLE+2 cycles apart.
- R7: A long packet is made of consecutive writes of up to MAX_BURST words (default 8). Its last write has bus_pktend_n low in the same cycle as bus_wr_n.
- R8: A write to address 2 in a cycle where bus_wmark (active high) is high carries bus_pktend_n low and is the last write of that packet.
- R9: Every write to address 6 carries bus_pktend_n low, so each short packet holds exactly one word.
- R10: A source's ready is high only in the cycle its word is written, and in that cycle bus_data equals that source's data.
- R11: bus_pktend_n is never low without bus_wr_n low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| long_data | input | DW | Word from the long-packet source |
| long_valid | input | 1 | Long source has a word |
| long_ready | output | 1 | Long source word is consumed this cycle |
| short_data | input | DW | Word from the single-word source |
| short_valid | input | 1 | Short source has a word |
| short_ready | output | 1 | Short source word is consumed this cycle |
| bus_ready | input | 1 | Bridge flag: addressed FIFO can accept data |
| bus_wmark | input | 1 | Bridge flag: addressed FIFO reached its watermark |
| bus_addr | output | AW | FIFO address (2 or 6) |
| bus_data | output | DW | Data to the bridge |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_pktend_n | output | 1 | Active-low packet-end strobe |
| bus_epsw_n | output | 1 | Active-low endpoint-switch strobe |

## Verification
A wrong turn state shows at once on the address and switch pins: the interval between switch pulses changes from SETTLE+2 (skipped turn) or the address fails to alternate in the very next turn. A wrong settle count moves the first write of a turn away from the SETTLE+1 mark. A wrong burst count or a lost watermark shows within one packet as a wrong length or a missing packet-end. A write leaking past a low ready flag is seen in the same cycle against the bridge model, which also checks that its buffer never overflows.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

   // Turn sequencing states
   typedef enum logic [1:0] {
      ST_WAIT   = 2'd0,   // address settling, flags ignored
      ST_SWITCH = 2'd1,   // new address shown, switch strobe low
      ST_CHECK  = 2'd2,   // single flag sample: first write or skip
      ST_BURST  = 2'd3    // remaining words of a long packet
   } sfw_state_e;

   // Which destination the current turn serves
   typedef enum logic {
      SIDE_LONG  = 1'b0,
      SIDE_SHORT = 1'b1
   } sfw_side_e;

endpackage

// File: rtl/sfw_settle_timer.sv
module sfw_settle_timer #(
   parameter int unsigned SETTLE = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic done
);

   localparam int unsigned CW = (SETTLE < 2) ? 1 : $clog2(SETTLE);
   localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (run && !done) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == LAST);

endmodule

// File: rtl/sfw_pkt_counter.sv
module sfw_pkt_counter #(
   parameter int unsigned MAX_BURST = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic wr,
   output logic at_limit
);

   localparam int unsigned CW = $clog2(MAX_BURST);
   localparam logic [CW-1:0] LAST = CW'(MAX_BURST - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (wr) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/sfw_src_mux.sv
module sfw_src_mux #(
   parameter int unsigned DW = 16,
   parameter int unsigned NL = 2,
   parameter int unsigned SW = (NL < 2) ? 1 : $clog2(NL)
) (
   input  logic [SW-1:0]        sel,
   input  logic                 fire,
   input  logic [NL-1:0][DW-1:0] lane_data,
   input  logic [NL-1:0]        lane_valid,
   output logic [DW-1:0]        data,
   output logic                 valid,
   output logic [NL-1:0]        lane_ready
);

   assign data  = lane_data[sel];
   assign valid = lane_valid[sel];

   for (genvar g = 0; g < NL; g++) begin : g_lane
      assign lane_ready[g] = fire && (sel == SW'(g));
   end

endmodule

// File: rtl/slvfifo_wr_ctrl.sv
module slvfifo_wr_ctrl
   import sfw_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned AW         = 5,
   parameter int unsigned ADDR_LONG  = 2,
   parameter int unsigned ADDR_SHORT = 6,
   parameter int unsigned SETTLE     = 3,
   parameter int unsigned MAX_BURST  = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] long_data,
   input  logic          long_valid,
   output logic          long_ready,
   input  logic [DW-1:0] short_data,
   input  logic          short_valid,
   output logic          short_ready,
   input  logic          bus_ready,
   input  logic          bus_wmark,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_data,
   output logic          bus_wr_n,
   output logic          bus_pktend_n,
   output logic          bus_epsw_n
);

   localparam int unsigned NL = 2;
   localparam logic [AW-1:0] A_LONG  = AW'(ADDR_LONG);
   localparam logic [AW-1:0] A_SHORT = AW'(ADDR_SHORT);

   // elaboration-time parameter checks
   if (SETTLE < 1) begin : g_bad_settle
      $error("slvfifo_wr_ctrl: SETTLE must be at least 1");
   end
   if (MAX_BURST < 2) begin : g_bad_burst
      $error("slvfifo_wr_ctrl: MAX_BURST must be at least 2");
   end
   if (ADDR_LONG == ADDR_SHORT) begin : g_bad_addr_eq
      $error("slvfifo_wr_ctrl: the two destinations must differ");
   end
   if ((ADDR_LONG >= (1 << AW)) || (ADDR_SHORT >= (1 << AW))) begin : g_bad_addr_w
      $error("slvfifo_wr_ctrl: destination address does not fit AW");
   end

   sfw_state_e state_q, state_d;
   sfw_side_e  side_q, side_d;

   logic          settle_done;
   logic          at_limit;
   logic          fire;
   logic          pkt_last;
   logic          sel_valid;
   logic [DW-1:0] sel_data;
   logic [NL-1:0] lane_ready;
   logic [NL-1:0][DW-1:0] lane_data;
   logic [NL-1:0] lane_valid;

   assign lane_data  = {short_data, long_data};
   assign lane_valid = {short_valid, long_valid};

   sfw_src_mux #(
      .DW (DW),
      .NL (NL)
   ) i_src_mux (
      .sel        (side_q == SIDE_SHORT),
      .fire       (fire),
      .lane_data  (lane_data),
      .lane_valid (lane_valid),
      .data       (sel_data),
      .valid      (sel_valid),
      .lane_ready (lane_ready)
   );

   sfw_settle_timer #(
      .SETTLE (SETTLE)
   ) i_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_SWITCH),
      .run   (state_q == ST_WAIT),
      .done  (settle_done)
   );

   sfw_pkt_counter #(
      .MAX_BURST (MAX_BURST)
   ) i_pkt_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state_q == ST_SWITCH),
      .wr       (fire),
      .at_limit (at_limit)
   );

   // a write happens only in a flag-sampling state with ready and data
   assign fire = ((state_q == ST_CHECK) || (state_q == ST_BURST)) && bus_ready && sel_valid;

   // short packets always end on their word; long ones on cap or watermark
   assign pkt_last = (side_q == SIDE_SHORT) || bus_wmark || at_limit;

   always_comb begin
      state_d = state_q;
      side_d  = side_q;
      case (state_q)
         ST_WAIT: begin
            if (settle_done) state_d = ST_CHECK;
         end
         ST_SWITCH: begin
            state_d = ST_WAIT;
         end
         ST_CHECK: begin
            if (!fire || pkt_last) begin
               state_d = ST_SWITCH;
               side_d  = (side_q == SIDE_LONG) ? SIDE_SHORT : SIDE_LONG;
            end else begin
               state_d = ST_BURST;
            end
         end
         ST_BURST: begin
            if (fire && pkt_last) begin
               state_d = ST_SWITCH;
               side_d  = (side_q == SIDE_LONG) ? SIDE_SHORT : SIDE_LONG;
            end
         end
         default: state_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         side_q  <= SIDE_LONG;
      end else begin
         state_q <= state_d;
         side_q  <= side_d;
      end
   end

   assign bus_addr     = (side_q == SIDE_SHORT) ? A_SHORT : A_LONG;
   assign bus_data     = sel_data;
   assign bus_wr_n     = !fire;
   assign bus_pktend_n = !(fire && pkt_last);
   assign bus_epsw_n   = (state_q != ST_SWITCH);
   assign long_ready   = lane_ready[0];
   assign short_ready  = lane_ready[1];

endmodule

// File: rtl/slvfifo_wr_ctrl_chk.sv
module slvfifo_wr_ctrl_chk #(
   parameter int unsigned AW         = 5,
   parameter int unsigned ADDR_LONG  = 2,
   parameter int unsigned ADDR_SHORT = 6,
   parameter int unsigned SETTLE     = 3,
   parameter int unsigned MAX_BURST  = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_wr_n,
   input logic          bus_pktend_n,
   input logic          bus_epsw_n,
   input logic          bus_ready,
   input logic          bus_wmark,
   input logic          long_valid,
   input logic          long_ready,
   input logic          short_valid,
   input logic          short_ready
);

   localparam logic [AW-1:0] A_L = AW'(ADDR_LONG);
   localparam logic [AW-1:0] A_S = AW'(ADDR_SHORT);
   localparam int unsigned AGE_W = $clog2(SETTLE + 2) + 1;
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SETTLE + 1);
   localparam int unsigned BW = $clog2(MAX_BURST + 1);
   localparam logic [BW-1:0] B_MAX  = BW'(MAX_BURST);
   localparam logic [BW-1:0] B_LAST = BW'(MAX_BURST - 1);

   logic [AW-1:0]    prev_addr_q;
   logic [AGE_W-1:0] age_q;
   logic [BW-1:0]    words_q;
   logic             wr;
   logic             moved;

   assign wr    = !bus_wr_n;
   assign moved = (bus_addr != prev_addr_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_addr_q <= A_L;
         age_q       <= AGE_W'(1);
         words_q     <= '0;
      end else begin
         prev_addr_q <= bus_addr;
         if (moved) age_q <= AGE_W'(1);
         else if (age_q < AGE_MAX) age_q <= age_q + 1'b1;
         if (wr && (bus_addr == A_L)) words_q <= bus_pktend_n ? words_q + 1'b1 : '0;
      end
   end

   // R2
   addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_L) || (bus_addr == A_S));

   // R3
   epsw_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      moved |-> !bus_epsw_n);

   // R3
   epsw_only_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_epsw_n |-> moved);

   // R4
   settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (!moved && (age_q >= AGE_MAX)));

   // R5
   no_write_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> bus_ready);

   // R7
   burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bus_addr == A_L)) |-> (words_q < B_MAX));

   // R7
   burst_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bus_addr == A_L) && (words_q == B_LAST)) |-> !bus_pktend_n);

   // R8
   wmark_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bus_addr == A_L) && bus_wmark) |-> !bus_pktend_n);

   // R9
   short_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (bus_addr == A_S)) |-> !bus_pktend_n);

   // R10
   long_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      long_ready |-> (wr && long_valid && (bus_addr == A_L)));

   // R10
   short_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_ready |-> (wr && short_valid && (bus_addr == A_S)));

   // R11
   pktend_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_pktend_n |-> wr);

endmodule

bind slvfifo_wr_ctrl slvfifo_wr_ctrl_chk #(
   .AW         (AW),
   .ADDR_LONG  (ADDR_LONG),
   .ADDR_SHORT (ADDR_SHORT),
   .SETTLE     (SETTLE),
   .MAX_BURST  (MAX_BURST)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_wr_n     (bus_wr_n),
   .bus_pktend_n (bus_pktend_n),
   .bus_epsw_n   (bus_epsw_n),
   .bus_ready    (bus_ready),
   .bus_wmark    (bus_wmark),
   .long_valid   (long_valid),
   .long_ready   (long_ready),
   .short_valid  (short_valid),
   .short_ready  (short_ready)
);

// File: tb/test_slvfifo_wr_ctrl.sv
`timescale 1ns/1ps
module test_slvfifo_wr_ctrl;

   localparam int DW     = 16;
   localparam int AW     = 5;
   localparam int SETTLE = 3;
   localparam int MAXB   = 8;
   localparam int CAP    = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          lv = 1'b0, sv = 1'b0;
   logic [DW-1:0] seq_l = 16'h0000;
   logic [DW-1:0] seq_s = 16'h8000;
   logic          drv_rdy = 1'b0, drv_wm = 1'b0, use_model = 1'b0, drain_en = 1'b0;
   logic          m_rdy1 = 1'b0, m_rdy2 = 1'b0, m_wm1 = 1'b0, m_wm2 = 1'b0;
   int            fill = 0;
   int            tick_n = 0;

   logic          long_ready, short_ready;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;
   logic          bus_wr_n, bus_pktend_n, bus_epsw_n;
   logic          bus_ready, bus_wmark;

   assign bus_ready = use_model ? m_rdy2 : drv_rdy;
   assign bus_wmark = use_model ? m_wm2  : drv_wm;

   slvfifo_wr_ctrl #(
      .DW(DW), .AW(AW), .ADDR_LONG(2), .ADDR_SHORT(6), .SETTLE(SETTLE), .MAX_BURST(MAXB)
   ) i_slvfifo_wr_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .long_data    (seq_l),
      .long_valid   (lv),
      .long_ready   (long_ready),
      .short_data   (seq_s),
      .short_valid  (sv),
      .short_ready  (short_ready),
      .bus_ready    (bus_ready),
      .bus_wmark    (bus_wmark),
      .bus_addr     (bus_addr),
      .bus_data     (bus_data),
      .bus_wr_n     (bus_wr_n),
      .bus_pktend_n (bus_pktend_n),
      .bus_epsw_n   (bus_epsw_n)
   );

   // sources advance on handshake; bridge model with 2-cycle flag latency
   always @(posedge clk) begin
      if (long_ready)  seq_l <= seq_l + 1'b1;
      if (short_ready) seq_s <= seq_s + 1'b1;
      tick_n <= tick_n + 1;
      if (!rst_n) fill <= 0;
      else fill <= fill + (bus_wr_n ? 0 : 1)
                        - ((drain_en && fill > 0 && (tick_n % 2 == 0)) ? 1 : 0);
      m_rdy1 <= (fill <= CAP - 4);
      m_rdy2 <= m_rdy1;
      m_wm1  <= (fill >= CAP - 12);
      m_wm2  <= m_wm1;
   end

   int errs = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; use_model = 1'b0; drain_en = 1'b0;
      lv = 1'b0; sv = 1'b0; drv_rdy = 1'b0; drv_wm = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; drv_rdy = 1'b1; lv = 1'b1; sv = 1'b1;
      repeat (3) @(negedge clk);
      #1;
      chk(bus_wr_n === 1'b1 && bus_pktend_n === 1'b1, "R1", "strobes idle in reset",
          {bus_wr_n, bus_pktend_n}, 3);
      chk(bus_epsw_n === 1'b1, "R1", "switch strobe idle", bus_epsw_n, 1);
      chk(bus_addr === 5'd2, "R1", "reset address", bus_addr, 2);
      chk(long_ready === 1'b0 && short_ready === 1'b0, "R1", "no source consumed",
          {long_ready, short_ready}, 0);
   endtask

   task automatic t_long();
      int n = 0, first = -1, lastc = -1, k = 0, j = 0;
      bit data_ok = 1, quiet = 1;
      do_reset();
      lv = 1'b1; drv_rdy = 1'b1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk); #1;
         if (!bus_wr_n) begin
            if (first < 0) first = c;
            if (bus_data !== seq_l || !long_ready || bus_addr !== 5'd2) data_ok = 0;
            n++;
            if (!bus_pktend_n) begin lastc = c; break; end
         end else if (!bus_pktend_n) data_ok = 0;
      end
      chk(n == MAXB, "R7", "long packet length", n, MAXB);
      chk(lastc - first == MAXB - 1, "R7", "long packet contiguous", lastc - first, MAXB - 1);
      chk(data_ok, "R10", "long data and handshake (R11 pktend only with write)", data_ok, 1);
      @(negedge clk); #1;
      chk(!bus_epsw_n, "R3", "switch strobe after packet", bus_epsw_n, 0);
      chk(bus_addr == 5'd6, "R2", "second turn address", bus_addr, 6);
      for (k = 1; k < 20; k++) begin
         @(negedge clk); #1;
         if (!bus_wr_n) quiet = 0;
         if (!bus_epsw_n) break;
      end
      chk(k == SETTLE + 2, "R6", "skipped turn length", k, SETTLE + 2);
      chk(quiet, "R6", "no write on skipped turn", quiet, 1);
      chk(bus_addr == 5'd2, "R2", "back to long address", bus_addr, 2);
      for (j = 1; j < 20; j++) begin
         @(negedge clk); #1;
         if (!bus_wr_n) break;
      end
      chk(j == SETTLE + 1, "R4", "first write after switch", j, SETTLE + 1);
   endtask

   task automatic t_wmark();
      int n = 0;
      bit closed_on_wm = 0;
      do_reset();
      lv = 1'b1; drv_rdy = 1'b1;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         drv_wm = (n >= 3);
         #1;
         if (!bus_wr_n) begin
            n++;
            if (!bus_pktend_n) begin closed_on_wm = drv_wm; break; end
         end
      end
      chk(n == 4, "R8", "packet length with watermark", n, 4);
      chk(closed_on_wm, "R8", "end on watermark cycle", closed_on_wm, 1);
      @(negedge clk);
      drv_wm = 1'b0;
      #1;
      chk(!bus_epsw_n && bus_addr == 5'd6, "R8", "turn passes after watermark",
          bus_addr, 6);
   endtask

   task automatic t_pause();
      int n = 0, paused = 0, bad = 0;
      do_reset();
      lv = 1'b1; drv_rdy = 1'b1;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         if (n == 3 && paused < 2) begin drv_rdy = 1'b0; paused++; end
         else drv_rdy = 1'b1;
         #1;
         if (!drv_rdy && !bus_wr_n) bad++;
         if (!bus_wr_n) begin
            n++;
            if (!bus_pktend_n) break;
         end
      end
      chk(bad == 0, "R5", "writes while not ready", bad, 0);
      chk(n == MAXB, "R5", "burst resumes to full length", n, MAXB);
   endtask

   task automatic t_skip();
      int writes = 0, pulses = 0, last_p = -1, bad_int = 0, bad_alt = 0;
      logic [AW-1:0] last_a = 5'd2;
      do_reset();
      lv = 1'b1; sv = 1'b1; drv_rdy = 1'b0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk); #1;
         if (!bus_wr_n || long_ready || short_ready) writes++;
         if (!bus_epsw_n) begin
            if (last_p >= 0 && c - last_p != SETTLE + 2) bad_int++;
            if (bus_addr == last_a) bad_alt++;
            last_a = bus_addr;
            last_p = c;
            pulses++;
         end
      end
      chk(writes == 0, "R6", "no write while never ready", writes, 0);
      chk(pulses >= 8, "R6", "turns keep moving", pulses, 8);
      chk(bad_int == 0, "R6", "skip interval errors", bad_int, 0);
      chk(bad_alt == 0, "R2", "address alternation errors", bad_alt, 0);
   endtask

   task automatic t_short();
      int w = 0, bad = 0;
      do_reset();
      sv = 1'b1; drv_rdy = 1'b1;
      for (int c = 0; c < 80; c++) begin
         @(negedge clk); #1;
         if (!bus_wr_n) begin
            w++;
            if (bus_addr !== 5'd6 || bus_pktend_n || bus_data !== seq_s || !short_ready) bad++;
         end
      end
      chk(w >= 6, "R9", "short packets sent", w, 6);
      chk(bad == 0, "R9", "single-word short packet errors (R10 data)", bad, 0);
   endtask

   task automatic t_model();
      int viol = 0, ovf = 0, plen = 0, bad_len = 0, bad_short = 0, orphan = 0;
      int wl = 0, ws = 0;
      do_reset();
      use_model = 1'b1; drain_en = 1'b1; lv = 1'b1; sv = 1'b1;
      for (int c = 0; c < 3000; c++) begin
         @(negedge clk); #1;
         if (fill > CAP) ovf++;
         if (!bus_pktend_n && bus_wr_n) orphan++;
         if (!bus_wr_n) begin
            if (!bus_ready) viol++;
            if (bus_addr == 5'd2) begin
               wl++; plen++;
               if (!bus_pktend_n) begin
                  if (plen > MAXB) bad_len++;
                  plen = 0;
               end
            end else begin
               ws++;
               if (bus_pktend_n) bad_short++;
            end
         end
      end
      chk(viol == 0, "R5", "model: write while ready low", viol, 0);
      chk(ovf == 0, "R5", "model: buffer overflow", ovf, 0);
      chk(bad_len == 0, "R7", "model: long packet too long", bad_len, 0);
      chk(bad_short == 0, "R9", "model: short packet without end", bad_short, 0);
      chk(orphan == 0, "R11", "model: packet end without write", orphan, 0);
      chk(wl > 100 && ws > 50, "R7", "model: traffic on both addresses", wl + ws, 150);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_long();
      t_wmark();
      t_pause();
      t_skip();
      t_short();
      t_model();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule